// File: doc/BRIEF.md
# Machine-Check Status and Recovery Sequencer

This block sits beside a processor core and turns parity-error strobes from the instruction cache, the data cache and the address-translation buffer into a machine-check event. Each strobe is sorted into one of four status categories. When the event is taken, the block records the interrupted program counter and the current machine-state word, clears the enable bits of the state word (machine-check enable among them) and raises a one-cycle vector pulse. It then runs the recovery for that category: an instruction cache invalidate, a data cache invalidate, or a restore of the faulty translation entry from a good copy held elsewhere. A return strobe from the handler restores the saved state word, which releases the mask.

The instruction cache reports tag and data faults on a single strobe. The data cache reports a 3-bit fault kind with a page-attribute bit: 1 means the page is write-through, 0 means copy-back. Invalidating the data cache is safe only for write-through data, so a fault on a copy-back page is not recovered: it sets a sticky unrecoverable flag instead. Faults that arrive while machine checks are masked are kept pending per category and taken once the mask is released.

The state machine has six states. IDLE takes a pending fault when machine checks are enabled (IDLE to ENTER). ENTER drives the vector pulse and branches by category: instruction to INV_I, lookup or flush data faults to INV_D, translation faults to XLAT_FIX. Each of those holds its request until the matching acknowledge and then moves to WAIT_RET. WAIT_RET returns to IDLE on the return strobe.

Top module: `mchk_recovery_seq`

## Requirements
- R1: After reset the status is 0, the state word equals its reset value (0x1000 by default, machine-check enable at bit 12), no request or vector is active, the handler-busy output is 0, and the unrecoverable flag is 0.
- R2: An instruction cache fault sets status bit 0 (one-hot status: bit 0 instruction, bit 1 data lookup, bit 2 data flush, bit 3 translation).
- R3: Data cache kinds 0 (tag), 1 (data) and 2 (multi-bit), found on lookup, set status bit 1. Kinds 3 (data), 4 (U-bit), 5 (modified-bit) and 6 (forced flush), found on flush, set status bit 2. Kind 7 is ignored.
- R4: A fault sampled at clock edge N is taken at edge N+1 when idle and enabled. At that edge, save0 receives the program counter, save1 receives the state word, the state word loses all bits of the clear mask (0x1F00 by default), and the vector is high for exactly the following cycle.
- R5: Instruction-category recovery raises the instruction invalidate request. Both data categories raise the data invalidate request. Each request is held until its acknowledge and then drops.
- R6: Translation-category recovery raises the restore request with the index captured from the faulting strobe, held stable until acknowledged.
- R7: A data cache fault on a copy-back page (attribute 0) sets a sticky unrecoverable flag and causes no vector and no invalidate.
- R8: When parity checking is disabled, all fault strobes are dropped.
- R9: Faults arriving while the machine-check enable bit is 0, including during a handler, are held pending and are taken once the bit is set again.
- R10: The return strobe is acted on only in WAIT_RET. At that edge the state word is restored from save1 and the block goes idle. Elsewhere the strobe has no effect.
- R11: Among pending faults, the instruction category is taken first, then data lookup, then data flush, then translation.
- R12: At most one recovery request is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| parity_en | input | 1 | Parity checking enable |
| ic_err | input | 1 | Instruction cache fault strobe (tag or data) |
| dc_err | input | 1 | Data cache fault strobe |
| dc_kind | input | 3 | Data cache fault kind |
| dc_wt | input | 1 | Page attribute of the faulting access, 1 = write-through |
| tlb_err | input | 1 | Translation buffer fault strobe |
| tlb_idx | input | IDX_W | Faulting translation entry index |
| pc_in | input | AW | Current program counter |
| ms_wr_en | input | 1 | State word write enable |
| ms_wr_data | input | MS_W | State word write data |
| mc_return | input | 1 | Return-from-handler strobe |
| ic_inv_ack | input | 1 | Instruction invalidate done |
| dc_inv_ack | input | 1 | Data invalidate done |
| xlat_fix_ack | input | 1 | Translation restore done |
| mc_status | output | 4 | One-hot category of the last taken fault |
| save0 | output | AW | Saved return address |
| save1 | output | MS_W | Saved state word |
| mstate | output | MS_W | Current machine-state word |
| mc_vector | output | 1 | One-cycle vector pulse |
| ic_inv_req | output | 1 | Instruction cache invalidate request |
| dc_inv_req | output | 1 | Data cache invalidate request |
| xlat_fix_req | output | 1 | Translation entry restore request |
| xlat_fix_idx | output | IDX_W | Entry to restore |
| in_handler | output | 1 | Sequencer busy (not IDLE) |
| unrec_flag | output | 1 | Sticky copy-back fault flag |

## Verification
Single faults are driven through every data cache kind, so each kind's category and its invalidate target are checked separately from the other kinds. Kind 7, a copy-back page and disabled parity are each applied and then checked for the absence of any vector, which separates dropped faults from taken ones. A fault raised while the enable bit is cleared, and a translation fault raised during another handler, show that pending faults are held and taken later. Three strobes raised in the same cycle show the category order. In every handler a return pulse is sent while the request is still open, which confirms that the return is ignored outside WAIT_RET.

// File: rtl/mchk_pkg.sv
`timescale 1ns/1ps
package mchk_pkg;
    localparam int NCAT      = 4;
    localparam int CAT_IC    = 0;
    localparam int CAT_DSRCH = 1;
    localparam int CAT_DFLSH = 2;
    localparam int CAT_XLAT  = 3;

    // data cache fault kinds: lookup group below flush group
    localparam logic [2:0] DK_LAST_LOOKUP = 3'd2;
    localparam logic [2:0] DK_LAST_FLUSH  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_INV_I,
        ST_INV_D,
        ST_XLAT_FIX,
        ST_WAIT_RET
    } seq_state_t;
endpackage

// File: rtl/mchk_classify.sv
`timescale 1ns/1ps
module mchk_classify
    import mchk_pkg::*;
(
    input  logic            chk_en,
    input  logic            ic_err,
    input  logic            dc_err,
    input  logic [2:0]      dc_kind,
    input  logic            dc_wt,
    input  logic            tlb_err,
    output logic [NCAT-1:0] raise,
    output logic            unrec
);
    logic dc_lookup;
    logic dc_flush;

    always_comb begin
        dc_lookup = dc_err && (dc_kind <= DK_LAST_LOOKUP);
        dc_flush  = dc_err && (dc_kind > DK_LAST_LOOKUP) && (dc_kind <= DK_LAST_FLUSH);
        raise     = '0;
        unrec     = 1'b0;
        if (chk_en) begin
            raise[CAT_IC]    = ic_err;
            raise[CAT_DSRCH] = dc_lookup && dc_wt;
            raise[CAT_DFLSH] = dc_flush && dc_wt;
            raise[CAT_XLAT]  = tlb_err;
            unrec            = (dc_lookup || dc_flush) && !dc_wt;
        end
    end
endmodule

// File: rtl/mchk_pending.sv
`timescale 1ns/1ps
module mchk_pending
    import mchk_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCAT-1:0]  raise,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             take,
    output logic [NCAT-1:0]  pick,
    output logic             any,
    output logic [IDX_W-1:0] idx_q
);
    logic [NCAT-1:0] pend_q;
    logic [NCAT-1:0] pend_d;

    // fixed priority: lower category index wins
    for (genvar g = 0; g < NCAT; g++) begin : g_pri
        if (g == 0) begin : g_top
            assign pick[g] = pend_q[g];
        end else begin : g_rest
            assign pick[g] = pend_q[g] & ~(|pend_q[g-1:0]);
        end
    end

    assign any = |pend_q;

    always_comb begin
        pend_d = (pend_q & ~(take ? pick : '0)) | raise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            idx_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (raise[CAT_XLAT]) begin
                idx_q <= idx_in;
            end
        end
    end
endmodule

// File: rtl/mchk_recovery_seq.sv
`timescale 1ns/1ps
module mchk_recovery_seq
    import mchk_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              MS_W       = 16,
    parameter int              IDX_W      = 6,
    parameter int              ME_BIT     = 12,
    parameter logic [MS_W-1:0] CLEAR_MASK = 16'h1F00,
    parameter logic [MS_W-1:0] MS_RESET   = 16'h1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             parity_en,
    input  logic             ic_err,
    input  logic             dc_err,
    input  logic [2:0]       dc_kind,
    input  logic             dc_wt,
    input  logic             tlb_err,
    input  logic [IDX_W-1:0] tlb_idx,
    input  logic [AW-1:0]    pc_in,
    input  logic             ms_wr_en,
    input  logic [MS_W-1:0]  ms_wr_data,
    input  logic             mc_return,
    input  logic             ic_inv_ack,
    input  logic             dc_inv_ack,
    input  logic             xlat_fix_ack,
    output logic [3:0]       mc_status,
    output logic [AW-1:0]    save0,
    output logic [MS_W-1:0]  save1,
    output logic [MS_W-1:0]  mstate,
    output logic             mc_vector,
    output logic             ic_inv_req,
    output logic             dc_inv_req,
    output logic             xlat_fix_req,
    output logic [IDX_W-1:0] xlat_fix_idx,
    output logic             in_handler,
    output logic             unrec_flag
);
    seq_state_t      state_q, state_d;
    logic [NCAT-1:0] raise;
    logic [NCAT-1:0] pick;
    logic            pend_any;
    logic            unrec_set;
    logic [IDX_W-1:0] pend_idx;
    logic            take;
    logic            ret_ok;

    mchk_classify u_cls (
        .chk_en  (parity_en),
        .ic_err  (ic_err),
        .dc_err  (dc_err),
        .dc_kind (dc_kind),
        .dc_wt   (dc_wt),
        .tlb_err (tlb_err),
        .raise   (raise),
        .unrec   (unrec_set)
    );

    mchk_pending #(.IDX_W(IDX_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (raise),
        .idx_in (tlb_idx),
        .take   (take),
        .pick   (pick),
        .any    (pend_any),
        .idx_q  (pend_idx)
    );

    assign take   = (state_q == ST_IDLE) && mstate[ME_BIT] && pend_any;
    assign ret_ok = (state_q == ST_WAIT_RET) && mc_return;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = ST_ENTER;
            end
            ST_ENTER: begin
                if (mc_status[CAT_IC])                              state_d = ST_INV_I;
                else if (mc_status[CAT_DSRCH] || mc_status[CAT_DFLSH]) state_d = ST_INV_D;
                else                                                state_d = ST_XLAT_FIX;
            end
            ST_INV_I: begin
                if (ic_inv_ack) state_d = ST_WAIT_RET;
            end
            ST_INV_D: begin
                if (dc_inv_ack) state_d = ST_WAIT_RET;
            end
            ST_XLAT_FIX: begin
                if (xlat_fix_ack) state_d = ST_WAIT_RET;
            end
            ST_WAIT_RET: begin
                if (mc_return) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // context and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_status    <= '0;
            save0        <= '0;
            save1        <= '0;
            mstate       <= MS_RESET;
            xlat_fix_idx <= '0;
            unrec_flag   <= 1'b0;
        end else begin
            if (take) begin
                mc_status <= pick;
                save0     <= pc_in;
                save1     <= mstate;
                mstate    <= mstate & ~CLEAR_MASK;
                if (pick[CAT_XLAT]) xlat_fix_idx <= pend_idx;
            end else if (ret_ok) begin
                mstate <= save1;
            end else if (ms_wr_en) begin
                mstate <= ms_wr_data;
            end
            if (unrec_set) unrec_flag <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        mc_vector    = (state_q == ST_ENTER);
        ic_inv_req   = (state_q == ST_INV_I);
        dc_inv_req   = (state_q == ST_INV_D);
        xlat_fix_req = (state_q == ST_XLAT_FIX);
        in_handler   = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/mchk_recovery_chk.sv
`timescale 1ns/1ps
module mchk_recovery_chk #(
    parameter int MS_W   = 16,
    parameter int IDX_W  = 6,
    parameter int ME_BIT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       mc_status,
    input logic [MS_W-1:0]  save1,
    input logic [MS_W-1:0]  mstate,
    input logic             mc_vector,
    input logic             ic_inv_req,
    input logic             dc_inv_req,
    input logic             xlat_fix_req,
    input logic             ic_inv_ack,
    input logic             xlat_fix_ack,
    input logic [IDX_W-1:0] xlat_fix_idx,
    input logic             in_handler,
    input logic             mc_return,
    input logic             unrec_flag
);
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ic_inv_req, dc_inv_req, xlat_fix_req})); // R12
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mc_status)); // R2
    AST_VECTOR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mc_vector |=> !mc_vector); // R4
    AST_VECTOR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mc_vector |-> !mstate[ME_BIT]); // R4
    AST_IC_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_inv_req && !ic_inv_ack) |=> ic_inv_req); // R5
    AST_IC_REQ_CAT: assert property (@(posedge clk) disable iff (!rst_n)
        ic_inv_req |-> mc_status[0]); // R5
    AST_DC_REQ_CAT: assert property (@(posedge clk) disable iff (!rst_n)
        dc_inv_req |-> (mc_status[1] || mc_status[2])); // R3
    AST_FIX_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_fix_req && !xlat_fix_ack) |=> $stable(xlat_fix_idx)); // R6
    AST_UNREC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unrec_flag |=> unrec_flag); // R7
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && !mc_vector && !ic_inv_req && !dc_inv_req && !xlat_fix_req && mc_return)
        |=> (mstate == $past(save1) && !in_handler)); // R10
endmodule

bind mchk_recovery_seq mchk_recovery_chk #(
    .MS_W(MS_W), .IDX_W(IDX_W), .ME_BIT(ME_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mc_status(mc_status), .save1(save1),
    .mstate(mstate), .mc_vector(mc_vector), .ic_inv_req(ic_inv_req),
    .dc_inv_req(dc_inv_req), .xlat_fix_req(xlat_fix_req),
    .ic_inv_ack(ic_inv_ack), .xlat_fix_ack(xlat_fix_ack),
    .xlat_fix_idx(xlat_fix_idx), .in_handler(in_handler),
    .mc_return(mc_return), .unrec_flag(unrec_flag)
);

// File: tb/sim_mchk_recovery_seq.sv
`timescale 1ns/1ps
module sim_mchk_recovery_seq;
    localparam logic [15:0] MASK = 16'h1F00;

    typedef struct packed {
        logic [3:0]  cat;
        logic [31:0] pc;
        logic [15:0] ms;
        logic [5:0]  idx;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic parity_en = 1, ic_err = 0, dc_err = 0, dc_wt = 0, tlb_err = 0;
    logic [2:0]  dc_kind = 0;
    logic [5:0]  tlb_idx = 0;
    logic [31:0] pc_in = 0;
    logic ms_wr_en = 0;
    logic [15:0] ms_wr_data = 0;
    logic mc_return = 0, ic_inv_ack = 0, dc_inv_ack = 0, xlat_fix_ack = 0;
    logic [3:0]  mc_status;
    logic [31:0] save0;
    logic [15:0] save1, mstate;
    logic mc_vector, ic_inv_req, dc_inv_req, xlat_fix_req, in_handler, unrec_flag;
    logic [5:0] xlat_fix_idx;

    int n_chk = 0, n_fail = 0, vec_cnt = 0, done_cnt = 0;
    logic [15:0] ms_model = 16'h1000;
    exp_t q[$];

    always #2.5 clk = ~clk;

    mchk_recovery_seq u0 (
        .clk(clk), .rst_n(rst_n), .parity_en(parity_en), .ic_err(ic_err),
        .dc_err(dc_err), .dc_kind(dc_kind), .dc_wt(dc_wt), .tlb_err(tlb_err),
        .tlb_idx(tlb_idx), .pc_in(pc_in), .ms_wr_en(ms_wr_en), .ms_wr_data(ms_wr_data),
        .mc_return(mc_return), .ic_inv_ack(ic_inv_ack), .dc_inv_ack(dc_inv_ack),
        .xlat_fix_ack(xlat_fix_ack), .mc_status(mc_status), .save0(save0),
        .save1(save1), .mstate(mstate), .mc_vector(mc_vector), .ic_inv_req(ic_inv_req),
        .dc_inv_req(dc_inv_req), .xlat_fix_req(xlat_fix_req), .xlat_fix_idx(xlat_fix_idx),
        .in_handler(in_handler), .unrec_flag(unrec_flag)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] cat, input logic [5:0] idx);
        exp_t e;
        e.cat = cat; e.pc = pc_in; e.ms = ms_model; e.idx = idx;
        q.push_back(e);
    endtask

    task automatic fire(input bit i, input bit d, input logic [2:0] k, input bit wt,
                        input bit t, input logic [5:0] ix);
        @(negedge clk);
        ic_err = i; dc_err = d; dc_kind = k; dc_wt = wt; tlb_err = t; tlb_idx = ix;
        @(negedge clk);
        ic_err = 0; dc_err = 0; dc_kind = 0; dc_wt = 0; tlb_err = 0; tlb_idx = 0;
    endtask

    task automatic wr_ms(input logic [15:0] v);
        @(negedge clk); ms_wr_en = 1; ms_wr_data = v;
        @(negedge clk); ms_wr_en = 0;
        ms_model = v;
    endtask

    task automatic wait_done(input int n, input string tag);
        for (int i = 0; i < 400 && done_cnt < n; i++) @(negedge clk);
        chk(done_cnt == n, tag, done_cnt, n);
    endtask

    // monitor: pops the scoreboard on every vector and services the handler
    initial begin
        exp_t e;
        logic [2:0] rq, erq;
        bit got;
        forever begin
            @(negedge clk);
            if (mc_vector) begin
                vec_cnt++;
                if (q.size() == 0) begin
                    chk(0, "R4 vector with no fault expected", {28'd0, mc_status}, 0);
                end else begin
                    e = q.pop_front();
                    chk(mc_status == e.cat, "R2 R3 R11 status category", {28'd0, mc_status}, {28'd0, e.cat});
                    chk(save0 == e.pc, "R4 save0", save0, e.pc);
                    chk(save1 == e.ms, "R4 save1", {16'd0, save1}, {16'd0, e.ms});
                    chk(mstate == (e.ms & ~MASK), "R4 masked state", {16'd0, mstate}, {16'd0, e.ms & ~MASK});
                    got = 0;
                    for (int i = 0; i < 10 && !got; i++) begin
                        @(negedge clk);
                        if (ic_inv_req || dc_inv_req || xlat_fix_req) got = 1;
                    end
                    rq  = {xlat_fix_req, dc_inv_req, ic_inv_req};
                    erq = e.cat[0] ? 3'b001 : ((e.cat[1] || e.cat[2]) ? 3'b010 : 3'b100);
                    chk(rq == erq, "R5 recovery request kind", {29'd0, rq}, {29'd0, erq});
                    if (e.cat[3]) chk(xlat_fix_idx == e.idx, "R6 restore index", {26'd0, xlat_fix_idx}, {26'd0, e.idx});
                    mc_return = 1;
                    @(negedge clk);
                    mc_return = 0;
                    rq = {xlat_fix_req, dc_inv_req, ic_inv_req};
                    chk(rq == erq, "R10 return ignored during recovery", {29'd0, rq}, {29'd0, erq});
                    ic_inv_ack = erq[0]; dc_inv_ack = erq[1]; xlat_fix_ack = erq[2];
                    @(negedge clk);
                    ic_inv_ack = 0; dc_inv_ack = 0; xlat_fix_ack = 0;
                    rq = {xlat_fix_req, dc_inv_req, ic_inv_req};
                    chk(rq == 0 && in_handler, "R5 request drops after ack", {28'd0, in_handler, rq}, 32'h8);
                    @(negedge clk);
                    mc_return = 1;
                    @(negedge clk);
                    mc_return = 0;
                    chk(mstate == e.ms && !in_handler, "R10 state restored on return", {15'd0, in_handler, mstate}, {16'd0, e.ms});
                    done_cnt++;
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base, v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(mc_status == 0, "R1 status after reset", {28'd0, mc_status}, 0);
        chk(mstate == 16'h1000, "R1 state word after reset", {16'd0, mstate}, 32'h1000);
        chk({mc_vector, ic_inv_req, dc_inv_req, xlat_fix_req, in_handler, unrec_flag} == 0,
            "R1 outputs idle after reset",
            {26'd0, mc_vector, ic_inv_req, dc_inv_req, xlat_fix_req, in_handler, unrec_flag}, 0);

        // R2 instruction cache fault
        pc_in = 32'h0000_0100;
        push(4'b0001, 0); fire(1, 0, 0, 0, 0, 0);
        wait_done(1, "R2 instruction fault serviced");

        // R3 every data cache kind on a write-through page
        for (int k = 0; k < 7; k++) begin
            pc_in = 32'h200 + k * 4;
            push((k < 3) ? 4'b0010 : 4'b0100, 0);
            fire(0, 1, 3'(k), 1, 0, 0);
            wait_done(2 + k, "R3 data fault serviced");
        end

        // R6 translation fault
        pc_in = 32'h0000_0300;
        push(4'b1000, 6'd37); fire(0, 0, 0, 0, 1, 6'd37);
        wait_done(9, "R6 translation fault serviced");

        // R3 reserved kind 7 ignored
        base = vec_cnt;
        fire(0, 1, 3'd7, 1, 0, 0);
        repeat (10) @(negedge clk);
        chk(vec_cnt == base, "R3 kind 7 ignored", vec_cnt, base);

        // R7 copy-back page fault
        fire(0, 1, 3'd4, 0, 0, 0);
        repeat (10) @(negedge clk);
        chk(vec_cnt == base, "R7 copy-back fault not taken", vec_cnt, base);
        chk(unrec_flag == 1, "R7 unrecoverable flag set", {31'd0, unrec_flag}, 1);

        // R8 parity disabled drops faults
        parity_en = 0;
        fire(1, 1, 3'd1, 1, 1, 6'd3);
        repeat (10) @(negedge clk);
        chk(vec_cnt == base, "R8 faults dropped when disabled", vec_cnt, base);
        parity_en = 1;

        // R9 fault while enable bit cleared is held
        wr_ms(16'h0000);
        pc_in = 32'h0000_0400;
        fire(1, 0, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        chk(vec_cnt == base, "R9 fault held while masked", vec_cnt, base);
        ms_model = 16'h1234;
        push(4'b0001, 0);
        wr_ms(16'h1234);
        wait_done(10, "R9 held fault taken after enable");

        // R9 fault during a handler is taken after return
        pc_in = 32'h0000_0500;
        push(4'b0001, 0); push(4'b1000, 6'd5);
        fire(1, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        fire(0, 0, 0, 0, 1, 6'd5);
        wait_done(12, "R9 fault raised in handler taken later");

        // R11 simultaneous faults in priority order
        pc_in = 32'h0000_0600;
        push(4'b0001, 0); push(4'b0100, 0); push(4'b1000, 6'd9);
        fire(1, 1, 3'd6, 1, 1, 6'd9);
        wait_done(15, "R11 all simultaneous faults serviced");

        v = q.size();
        chk(v == 0, "R11 scoreboard drained", v, 0);
        chk(unrec_flag == 1, "R7 unrecoverable flag sticky", {31'd0, unrec_flag}, 1);
        finish_run();
    end
endmodule